// File: doc/BRIEF.md
# Two-Bank Shared Mailbox with Doorbell Trap

This block lets two agents, A and B, exchange data through shared memory on one clock. It holds two banks of 2^ADDR_W bytes each (1 KB by default). Each agent owns one bank. It may read and write its own bank and may only read the peer's bank. Operands and results sit in the low bytes of a bank, and both sides use them in place: nothing is copied from one bank to the other.

The highest address of each bank is the command byte. When an agent writes the command byte of its own bank, a trap fires and raises a doorbell interrupt to the other agent. The doorbell stays raised until that agent pulses its clear input. A write aimed at the read-only bank changes nothing in memory and sets a sticky error flag for the agent that issued it.

Each agent port carries an address, a bank select, a write enable, write data, a read-data output, an interrupt output, an interrupt clear and an error flag. A read returns its data one cycle after the address is presented.

Top module: `pair_mailbox`

## Requirements
- R1: While reset is high and on the first cycle after it, every output is zero: both read-data buses, both interrupts and both error flags.
- R2: The bank select is 0 for bank A and 1 for bank B. A write by agent A with select 0, or by agent B with select 1, stores the data. A read of that address presented on the next cycle returns the data one cycle after it is presented.
- R3: Either agent can read either bank. Agent B sees the contents of bank A that agent A wrote, and agent A sees the contents of bank B that agent B wrote.
- R4: A write by agent A with select 1, or by agent B with select 0, leaves memory unchanged. It sets that agent's error flag on the next cycle, and the flag then stays high until reset.
- R5: A legal write to address 2^ADDR_W-1 of the writer's own bank sets the peer's interrupt on the next cycle. A legal write to any other address does not set it.
- R6: An interrupt stays high until its owner's clear input is high at a clock edge with no new trap in that cycle. It is low on the following cycle.
- R7: A trap in the same cycle as a clear of the same interrupt leaves the interrupt high.
- R8: A read of an address that its owner writes in the same cycle returns the old contents (read-first).
- R9: Both agents may write their own banks in the same cycle, at the same or different addresses, and both writes take effect.
- R10: A refused write to the command address of the read-only bank raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous active-high reset |
| a_addr | input | ADDR_W | Agent A byte address |
| a_bank | input | 1 | Agent A bank select (0 = bank A, 1 = bank B) |
| a_we | input | 1 | Agent A write enable |
| a_wdata | input | DATA_W | Agent A write data |
| a_rdata | output | DATA_W | Agent A read data, one cycle after the address |
| a_irq | output | 1 | Doorbell to agent A, raised by B's command write |
| a_irq_clr | input | 1 | Agent A clears its doorbell |
| a_err | output | 1 | Sticky flag for a write by A to bank B |
| b_addr | input | ADDR_W | Agent B byte address |
| b_bank | input | 1 | Agent B bank select (0 = bank A, 1 = bank B) |
| b_we | input | 1 | Agent B write enable |
| b_wdata | input | DATA_W | Agent B write data |
| b_rdata | output | DATA_W | Agent B read data, one cycle after the address |
| b_irq | output | 1 | Doorbell to agent B, raised by A's command write |
| b_irq_clr | input | 1 | Agent B clears its doorbell |
| b_err | output | 1 | Sticky flag for a write by B to bank A |

## Verification
A faulty write-rights decode shows up one cycle later in two places: the error flag rises when it should not, or a refused write corrupts the owner's bank, which appears on the next read of that address. A wrong doorbell state is visible on the interrupt pin in the cycle after the trap or clear. A bad priority between trap and clear shows up only when both land on the same edge, so the stimulus forces that case. A broken read path or bank select returns wrong data exactly one cycle after the address. The bench compares every output on every cycle against a bank-by-bank shadow model, so a fault surfaces within a cycle or two of its cause.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int NSIDE = 2;
  typedef enum logic {SIDE_A = 1'b0, SIDE_B = 1'b1} side_e;
endpackage

// File: rtl/mbox_bank.sv
// One writer, two registered readers; read-first on a same-address write.
module mbox_bank #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr0,
  input  logic [ADDR_W-1:0] raddr1,
  output logic [DATA_W-1:0] rdata0,
  output logic [DATA_W-1:0] rdata1
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata0 <= '0;
      rdata1 <= '0;
    end else begin
      rdata0 <= mem[raddr0];
      rdata1 <= mem[raddr1];
    end
  end
endmodule

// File: rtl/mbox_guard.sv
// Write-rights check for one agent: passes writes to its own bank,
// refuses the rest and latches a sticky error.
module mbox_guard #(
  parameter int ADDR_W = 10,
  parameter int OWN    = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              bank,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_ok,
  output logic              trap,
  output logic              err
);
  logic bad_wr;

  always_comb begin
    wr_ok  = we && (bank == 1'(OWN));
    bad_wr = we && (bank != 1'(OWN));
    trap   = wr_ok && (addr == '1);
  end

  always_ff @(posedge clk) begin
    if (rst)         err <= 1'b0;
    else if (bad_wr) err <= 1'b1;
  end

  a_r4_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
  a_r4_err_on_refused: assert property (@(posedge clk) disable iff (rst)
    (we && bank != 1'(OWN)) |=> err);
  a_r10_no_trap_refused: assert property (@(posedge clk) disable iff (rst)
    (we && bank != 1'(OWN)) |-> !trap);
endmodule

// File: rtl/mbox_trap.sv
// Doorbell flag: set by a trap, dropped by a clear; set wins.
module mbox_trap (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst)      irq <= 1'b0;
    else if (set) irq <= 1'b1;
    else if (clr) irq <= 1'b0;
  end

  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    set |=> irq);
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr) |=> irq);
  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !irq);
endmodule

// File: rtl/pair_mailbox.sv
module pair_mailbox
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_bank,
  input  logic              a_we,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_irq,
  input  logic              a_irq_clr,
  output logic              a_err,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_bank,
  input  logic              b_we,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_irq,
  input  logic              b_irq_clr,
  output logic              b_err
);
  logic [ADDR_W-1:0] addr_v  [NSIDE];
  logic              bank_v  [NSIDE];
  logic              we_v    [NSIDE];
  logic [DATA_W-1:0] wdata_v [NSIDE];
  logic              clr_v   [NSIDE];
  logic              wr_ok_v [NSIDE];
  logic              trap_v  [NSIDE];
  logic              err_v   [NSIDE];
  logic              irq_v   [NSIDE];
  logic              sel_q   [NSIDE];
  // rd_q[bank][agent]
  logic [DATA_W-1:0] rd_q    [NSIDE][NSIDE];
  logic [DATA_W-1:0] rdata_v [NSIDE];

  assign addr_v[SIDE_A]  = a_addr;
  assign addr_v[SIDE_B]  = b_addr;
  assign bank_v[SIDE_A]  = a_bank;
  assign bank_v[SIDE_B]  = b_bank;
  assign we_v[SIDE_A]    = a_we;
  assign we_v[SIDE_B]    = b_we;
  assign wdata_v[SIDE_A] = a_wdata;
  assign wdata_v[SIDE_B] = b_wdata;
  assign clr_v[SIDE_A]   = a_irq_clr;
  assign clr_v[SIDE_B]   = b_irq_clr;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    mbox_guard #(.ADDR_W(ADDR_W), .OWN(s)) u_guard (
      .clk   (clk),
      .rst   (rst),
      .we    (we_v[s]),
      .bank  (bank_v[s]),
      .addr  (addr_v[s]),
      .wr_ok (wr_ok_v[s]),
      .trap  (trap_v[s]),
      .err   (err_v[s])
    );

    // Bank s is written only by agent s and read by both.
    mbox_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .we     (wr_ok_v[s]),
      .waddr  (addr_v[s]),
      .wdata  (wdata_v[s]),
      .raddr0 (addr_v[SIDE_A]),
      .raddr1 (addr_v[SIDE_B]),
      .rdata0 (rd_q[s][SIDE_A]),
      .rdata1 (rd_q[s][SIDE_B])
    );

    // The doorbell to agent s is rung by the peer's trap.
    mbox_trap u_trap (
      .clk (clk),
      .rst (rst),
      .set (trap_v[NSIDE-1-s]),
      .clr (clr_v[s]),
      .irq (irq_v[s])
    );

    always_ff @(posedge clk) begin
      if (rst) sel_q[s] <= 1'b0;
      else     sel_q[s] <= bank_v[s];
    end

    assign rdata_v[s] = sel_q[s] ? rd_q[SIDE_B][s] : rd_q[SIDE_A][s];
  end

  assign a_rdata = rdata_v[SIDE_A];
  assign b_rdata = rdata_v[SIDE_B];
  assign a_irq   = irq_v[SIDE_A];
  assign b_irq   = irq_v[SIDE_B];
  assign a_err   = err_v[SIDE_A];
  assign b_err   = err_v[SIDE_B];

  a_r5_ring_b: assert property (@(posedge clk) disable iff (rst)
    (a_we && !a_bank && a_addr == '1) |=> b_irq);
  a_r5_ring_a: assert property (@(posedge clk) disable iff (rst)
    (b_we && b_bank && b_addr == '1) |=> a_irq);
  a_r5_no_ring_b: assert property (@(posedge clk) disable iff (rst)
    (!b_irq && !(a_we && !a_bank && a_addr == '1)) |=> !b_irq);
  a_r4_a_ro: assert property (@(posedge clk) disable iff (rst)
    (a_we && a_bank) |=> a_err);
endmodule

// File: tb/pair_mailbox_bench.sv
module pair_mailbox_bench;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] TOP = '1;

  logic clk = 1'b0;
  logic rst;
  logic [ADDR_W-1:0] a_addr, b_addr;
  logic a_bank, b_bank, a_we, b_we, a_irq_clr, b_irq_clr;
  logic [DATA_W-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic a_irq, b_irq, a_err, b_err;

  int n_chk  = 0;
  int n_fail = 0;

  logic [DATA_W-1:0] mem_m [2][DEPTH];
  bit                vld_m [2][DEPTH];
  bit m_irq_a, m_irq_b, m_err_a, m_err_b;

  always #(CLK_P/2) clk = ~clk;

  pair_mailbox #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pair_mailbox (
    .clk(clk), .rst(rst),
    .a_addr(a_addr), .a_bank(a_bank), .a_we(a_we), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_irq(a_irq), .a_irq_clr(a_irq_clr), .a_err(a_err),
    .b_addr(b_addr), .b_bank(b_bank), .b_we(b_we), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_irq(b_irq), .b_irq_clr(b_irq_clr), .b_err(b_err)
  );

  task automatic chk(input string lbl, input string nm,
                     input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", lbl, nm, act, exp);
    end
  endtask

  task automatic idle();
    a_we = 0; b_we = 0; a_irq_clr = 0; b_irq_clr = 0;
    a_bank = 0; b_bank = 1; a_addr = '0; b_addr = '0;
    a_wdata = '0; b_wdata = '0;
  endtask

  // Applies the current inputs for one edge and compares all outputs.
  task automatic step(input string lbl);
    logic [DATA_W-1:0] ea, eb;
    bit va, vb, ok_a, ok_b, set_a, set_b;
    va = vld_m[a_bank][a_addr]; ea = mem_m[a_bank][a_addr];
    vb = vld_m[b_bank][b_addr]; eb = mem_m[b_bank][b_addr];
    ok_a = a_we && !a_bank;
    ok_b = b_we && b_bank;
    if (ok_a) begin mem_m[0][a_addr] = a_wdata; vld_m[0][a_addr] = 1; end
    if (ok_b) begin mem_m[1][b_addr] = b_wdata; vld_m[1][b_addr] = 1; end
    if (a_we && a_bank)  m_err_a = 1;
    if (b_we && !b_bank) m_err_b = 1;
    set_b = ok_a && (a_addr == TOP);
    set_a = ok_b && (b_addr == TOP);
    m_irq_b = set_b || (m_irq_b && !b_irq_clr);
    m_irq_a = set_a || (m_irq_a && !a_irq_clr);
    @(posedge clk); #1;
    if (va) chk(lbl, "a_rdata", a_rdata, ea);
    if (vb) chk(lbl, "b_rdata", b_rdata, eb);
    chk(lbl, "a_irq", 8'(a_irq), 8'(m_irq_a));
    chk(lbl, "b_irq", 8'(b_irq), 8'(m_irq_b));
    chk(lbl, "a_err", 8'(a_err), 8'(m_err_a));
    chk(lbl, "b_err", 8'(b_err), 8'(m_err_b));
  endtask

  function automatic logic [ADDR_W-1:0] pick_addr(input int unsigned r);
    if (r % 8 == 0) return TOP;
    if (r % 8 == 1) return TOP - 1;
    return ADDR_W'((r >> 3) % 6);
  endfunction

  initial begin
    #(CLK_P * 60000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    idle();
    rst = 1;
    repeat (2) @(posedge clk);
    #1;
    // R1: outputs during reset
    chk("R1 reset", "a_rdata", a_rdata, 0);
    chk("R1 reset", "b_rdata", b_rdata, 0);
    chk("R1 reset", "a_irq", 8'(a_irq), 0);
    chk("R1 reset", "b_irq", 8'(b_irq), 0);
    chk("R1 reset", "a_err", 8'(a_err), 0);
    chk("R1 reset", "b_err", 8'(b_err), 0);
    rst = 0;
    step("R1 first cycle");

    // R2: own write then read back
    a_we = 1; a_addr = 5; a_wdata = 8'h3C; step("R2 write A");
    idle(); a_addr = 5; step("R2 read A addr");
    step("R2 read A data");
    // R3: B reads bank A
    b_bank = 0; b_addr = 5; step("R3 B reads A");
    step("R3 B reads A data");
    // R8: read-first while owner rewrites
    a_we = 1; a_addr = 5; a_wdata = 8'h77; b_bank = 0; b_addr = 5; step("R8 same-cycle");
    idle(); b_bank = 0; b_addr = 5; step("R8 new value");
    // R4: refused write keeps memory
    idle(); b_we = 1; b_addr = 9; b_wdata = 8'h11; step("R4 B writes own");
    idle(); a_we = 1; a_bank = 1; a_addr = 9; a_wdata = 8'h99; step("R4 refused write");
    idle(); a_bank = 1; a_addr = 9; step("R4 read after refuse");
    step("R4 sticky err");
    // R10: refused write to command address
    idle(); b_we = 1; b_bank = 0; b_addr = TOP; b_wdata = 8'h55; step("R10 refused trap");
    idle(); step("R10 no doorbell");
    // R5: command write rings peer, neighbour address does not
    idle(); a_we = 1; a_addr = TOP - 1; a_wdata = 8'h01; step("R5 non-command");
    idle(); a_we = 1; a_addr = TOP; a_wdata = 8'h02; step("R5 command");
    // R6: hold then clear
    idle(); step("R6 hold 1"); step("R6 hold 2");
    b_irq_clr = 1; step("R6 clear");
    idle(); step("R6 stays low");
    // R7: trap and clear together
    b_we = 1; b_addr = TOP; b_wdata = 8'hA0; step("R7 ring A");
    idle(); b_we = 1; b_addr = TOP; a_irq_clr = 1; step("R7 set wins");
    // R9: simultaneous own writes
    idle(); a_we = 1; a_addr = 3; a_wdata = 8'hC3;
    b_we = 1; b_addr = 3; b_wdata = 8'h3C; step("R9 both write");
    idle(); a_bank = 1; a_addr = 3; b_bank = 0; b_addr = 3; step("R9 cross addr");
    step("R9 cross read");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      a_we = 1'($urandom); a_bank = ($urandom % 5 == 0); a_addr = pick_addr($urandom);
      a_wdata = 8'($urandom); a_irq_clr = ($urandom % 4 == 0);
      b_we = 1'($urandom); b_bank = ($urandom % 5 != 0); b_addr = pick_addr($urandom);
      b_wdata = 8'($urandom); b_irq_clr = ($urandom % 4 == 0);
      if ($urandom % 3 == 0) a_bank = ~a_bank;
      if ($urandom % 3 == 0) b_bank = ~b_bank;
      step("R2 R3 R4 R5 R6 R7 R8 R9 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule